// File: doc/BRIEF.md
# Clock Out-of-Frequency Monitor

This block tracks how far each of several monitored clocks drifts from a 0 ppm reference and raises an out-of-frequency flag per input. Clock edges reach it as one-cycle pulses already brought into the system clock domain. The reference is either a crystal edge stream or any one of the monitored inputs, picked by a select input. A long measurement window, counted in reference edges, gives fine resolution in units of 1/16 ppm. The flag is raised at a set threshold and dropped only at a tighter clear threshold, which is the set threshold minus a programmable hysteresis.

A coarse detector runs in parallel on a much shorter window. It flags any input that has moved by more than 4000 ppm, so a clock that ramps away is caught long before the long window closes. Each output flag is the OR of the fine and the coarse status. A one-cycle strobe marks each update of the fine status. Every monitored clock is taken to have the same nominal frequency as the reference, so the expected edge count in a window equals the window length.

Top module: `oof_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `oof` is all zero and `win_done` is low.
- R2: A `ref_sel` value i below N_MON takes monitored input i as the reference. The values 4 to 7 take `xtal_edge` as the reference.
- R3: The long window closes on the LONG_EDGES-th reference edge after its start. `win_done` is high for exactly the one cycle after that edge. The short window closes the same way on every SHORT_EDGES-th reference edge.
- R4: When a long window closes with count m and E = LONG_EDGES, the fine status of that input is set if |m−E|·16·10^6 > `set_thr`·E. `set_thr` is in units of 1/16 ppm.
- R5: When a long window closes without setting the fine status, that status is cleared if |m−E|·16·10^6 ≤ C·E, where C = `set_thr`−`hyst` (or 0 if `hyst` ≥ `set_thr`). In all other cases it keeps its value.
- R6: A long window in which an input had no edges sets that input's fine status.
- R7: When a short window closes, the coarse status of each input becomes (|m−S|·16·10^6 > 64000·S), with S = SHORT_EDGES. That is a 4000 ppm limit. Between closes the coarse status holds its value.
- R8: `oof[i]` is the OR of the fine and coarse status of input i. Both change only when their own window closes.
- R9: A change of `ref_sel` restarts both windows. All counts are cleared and edges in that cycle are ignored, so the next `win_done` needs a full LONG_EDGES new reference edges.
- R10: A monitored edge that arrives in the same cycle as the closing reference edge is counted in the window that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| ref_sel | input | 3 | reference choice: 0..N_MON-1 picks an input, otherwise the crystal |
| xtal_edge | input | 1 | crystal edge pulse |
| mon_edge | input | N_MON | edge pulses of the monitored clocks |
| set_thr | input | 13 | set threshold, 1/16 ppm units (up to 8000 = 500 ppm) |
| hyst | input | 13 | hysteresis, 1/16 ppm units |
| oof | output | N_MON | per-input out-of-frequency flag |
| win_done | output | 1 | one-cycle strobe after each long window closes |

## Verification
Each monitored input is driven by a phase accumulator at a chosen offset. The offsets cover exact match, small offsets inside the band, offsets near the set threshold, offsets large enough for the coarse detector, and a stopped clock. These cases separate the fine set decision, the hysteresis hold and the coarse flag from one another. Reference selection is varied across the crystal, each input and the upper crystal codes. This shows which edge stream paces the windows, and that an input used as its own reference reads as exact. A mid-window change of selection is timed against the next strobe to show the restart.

// File: rtl/oofm_pkg.sv
package oofm_pkg;

    localparam int THR_W       = 13;
    localparam int PPM_SCALE   = 16_000_000;   // 1/16 ppm units per unit ratio
    localparam int FAST_UNITS  = 64_000;       // 4000 ppm in 1/16 ppm units
    localparam int SEL_W       = 3;

    typedef struct packed {
        logic restart;
        logic long_end;
        logic short_end;
    } win_evt_t;

    // true when dev/exp exceeds thr (1/16 ppm units), computed without division
    function automatic logic beyond(input logic [31:0] dev,
                                    input logic [31:0] exp_cnt,
                                    input logic [31:0] thr);
        logic [63:0] lhs;
        logic [63:0] rhs;
        lhs = 64'(dev) * 64'(PPM_SCALE);
        rhs = 64'(thr) * 64'(exp_cnt);
        return lhs > rhs;
    endfunction

    function automatic logic [31:0] abs_diff(input logic [31:0] a,
                                             input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/oofm_window_timer.sv
module oofm_window_timer
    import oofm_pkg::*;
#(
    parameter int N_MON       = 4,
    parameter int LONG_EDGES  = 2048,
    parameter int SHORT_EDGES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] ref_sel,
    input  logic             xtal_edge,
    input  logic [N_MON-1:0] mon_edge,
    output win_evt_t         evt
);
    localparam int LW = $clog2(LONG_EDGES);
    localparam int SW = $clog2(SHORT_EDGES);

    logic [SEL_W-1:0] sel_q;
    logic [LW-1:0]    long_cnt;
    logic [SW-1:0]    short_cnt;
    logic             ref_edge;

    // R2: reference source mux
    always_comb begin
        ref_edge = xtal_edge;
        for (int i = 0; i < N_MON; i++) begin
            if (ref_sel == SEL_W'(i)) ref_edge = mon_edge[i];
        end
    end

    always_comb begin
        evt.restart   = (ref_sel != sel_q);
        evt.long_end  = !evt.restart && ref_edge && (long_cnt == LW'(LONG_EDGES - 1));
        evt.short_end = !evt.restart && ref_edge && (short_cnt == SW'(SHORT_EDGES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            long_cnt  <= '0;
            short_cnt <= '0;
        end else if (evt.restart) begin        // R9
            sel_q     <= ref_sel;
            long_cnt  <= '0;
            short_cnt <= '0;
        end else if (ref_edge) begin
            long_cnt  <= evt.long_end  ? '0 : long_cnt + 1'b1;
            short_cnt <= evt.short_end ? '0 : short_cnt + 1'b1;
        end
    end

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (ref_sel != sel_q) |=> (long_cnt == '0 && short_cnt == '0))
        else $error("a_r9_restart_clears");

    a_r3_count_idle: assert property (@(posedge clk) disable iff (rst)
        (!ref_edge && ref_sel == sel_q) |=> $stable(long_cnt))
        else $error("a_r3_count_idle");

endmodule

// File: rtl/oofm_channel.sv
module oofm_channel
    import oofm_pkg::*;
#(
    parameter int LONG_EDGES  = 2048,
    parameter int SHORT_EDGES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_in,
    input  win_evt_t         evt,
    input  logic [THR_W-1:0] set_thr,
    input  logic [THR_W-1:0] clr_thr,
    output logic             precise,
    output logic             fast
);
    localparam int CW = $clog2(4 * LONG_EDGES) + 1;
    localparam int FW = $clog2(4 * SHORT_EDGES) + 1;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [FW-1:0] FMAX = '1;

    logic [CW-1:0] long_cnt, long_tot;
    logic [FW-1:0] short_cnt, short_tot;
    logic [31:0]   long_dev, short_dev;
    logic          set_hit, clr_ok, fast_hit;

    // R10: edge of the closing cycle is part of the window
    always_comb begin
        long_tot  = (long_cnt == CMAX)  ? CMAX : long_cnt + CW'(edge_in);
        short_tot = (short_cnt == FMAX) ? FMAX : short_cnt + FW'(edge_in);
        long_dev  = abs_diff(32'(long_tot), 32'(LONG_EDGES));
        short_dev = abs_diff(32'(short_tot), 32'(SHORT_EDGES));
        set_hit   = (long_tot == '0) || beyond(long_dev, 32'(LONG_EDGES), 32'(set_thr));
        clr_ok    = !beyond(long_dev, 32'(LONG_EDGES), 32'(clr_thr));
        fast_hit  = beyond(short_dev, 32'(SHORT_EDGES), 32'(FAST_UNITS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            long_cnt  <= '0;
            short_cnt <= '0;
            precise   <= 1'b0;
            fast      <= 1'b0;
        end else if (evt.restart) begin
            long_cnt  <= '0;
            short_cnt <= '0;
        end else begin
            if (evt.long_end) begin
                long_cnt <= '0;
                if (set_hit)     precise <= 1'b1;   // R4, R6
                else if (clr_ok) precise <= 1'b0;   // R5
            end else begin
                long_cnt <= long_tot;
            end
            if (evt.short_end) begin
                short_cnt <= '0;
                fast      <= fast_hit;              // R7
            end else begin
                short_cnt <= short_tot;
            end
        end
    end

    a_r8_precise_holds: assert property (@(posedge clk) disable iff (rst)
        !evt.long_end |=> $stable(precise))
        else $error("a_r8_precise_holds");

    a_r7_fast_holds: assert property (@(posedge clk) disable iff (rst)
        !evt.short_end |=> $stable(fast))
        else $error("a_r7_fast_holds");

    a_r6_no_edges: assert property (@(posedge clk) disable iff (rst)
        (evt.long_end && long_cnt == '0 && !edge_in) |=> precise)
        else $error("a_r6_no_edges");

endmodule

// File: rtl/oof_monitor.sv
module oof_monitor
    import oofm_pkg::*;
#(
    parameter int N_MON       = 4,
    parameter int LONG_EDGES  = 2048,
    parameter int SHORT_EDGES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ref_sel,
    input  logic             xtal_edge,
    input  logic [N_MON-1:0] mon_edge,
    input  logic [12:0]      set_thr,
    input  logic [12:0]      hyst,
    output logic [N_MON-1:0] oof,
    output logic             win_done
);
    win_evt_t         evt;
    logic [THR_W-1:0] clr_thr;
    logic [N_MON-1:0] precise, fast;

    // R5: clear threshold, floored at zero
    assign clr_thr = (set_thr > hyst) ? (set_thr - hyst) : '0;

    oofm_window_timer #(
        .N_MON(N_MON), .LONG_EDGES(LONG_EDGES), .SHORT_EDGES(SHORT_EDGES)
    ) timer_i (
        .clk(clk), .rst(rst), .ref_sel(ref_sel), .xtal_edge(xtal_edge),
        .mon_edge(mon_edge), .evt(evt)
    );

    for (genvar g = 0; g < N_MON; g++) begin : g_chan
        oofm_channel #(
            .LONG_EDGES(LONG_EDGES), .SHORT_EDGES(SHORT_EDGES)
        ) chan_i (
            .clk(clk), .rst(rst), .edge_in(mon_edge[g]), .evt(evt),
            .set_thr(set_thr), .clr_thr(clr_thr),
            .precise(precise[g]), .fast(fast[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) win_done <= 1'b0;
        else     win_done <= evt.long_end;          // R3
    end

    assign oof = precise | fast;                    // R8

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (oof == '0 && !win_done))
        else $error("a_r1_reset_quiet");

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done)
        else $error("a_r3_done_single");

    a_r9_no_done_after_switch: assert property (@(posedge clk) disable iff (rst)
        evt.restart |=> !win_done)
        else $error("a_r9_no_done_after_switch");

endmodule

// File: tb/oof_monitor_tb.sv
module oof_monitor_tb_top;
    localparam int N  = 4;
    localparam int L  = 2048;
    localparam int S  = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   ref_sel = 3'd4;
    logic         xtal_edge = 1'b0;
    logic [N-1:0] mon_edge = '0;
    logic [12:0]  set_thr = 13'd6000;
    logic [12:0]  hyst = 13'd2000;
    logic [N-1:0] oof;
    logic         win_done;

    int errors = 0, checks = 0, cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    oof_monitor #(.N_MON(N), .LONG_EDGES(L), .SHORT_EDGES(S)) dut_i (
        .clk(clk), .rst(rst), .ref_sel(ref_sel), .xtal_edge(xtal_edge),
        .mon_edge(mon_edge), .set_thr(set_thr), .hyst(hyst),
        .oof(oof), .win_done(win_done)
    );

    // phase-accumulator edge sources: index 0..3 monitored, 4 crystal
    logic [31:0] acc [5];
    logic [31:0] inc [5];

    function automatic logic [31:0] ppm_inc(input real ppm);
        return 32'(longint'(2147483648.0 * (1.0 + ppm * 1.0e-6)));
    endfunction

    initial begin
        for (int i = 0; i < 5; i++) begin acc[i] = '0; inc[i] = ppm_inc(0.0); end
    end

    always @(negedge clk) begin
        logic [32:0] s;
        for (int i = 0; i < 5; i++) begin
            s = {1'b0, acc[i]} + {1'b0, inc[i]};
            acc[i] = s[31:0];
            if (i < 4) mon_edge[i] <= s[32];
            else       xtal_edge   <= s[32];
        end
    end

    // reference model built from the requirements
    function automatic bit over(input longint dev, input longint e, input longint thr);
        return dev * 16000000 > thr * e;
    endfunction
    function automatic longint labs(input longint v);
        return v < 0 ? -v : v;
    endfunction

    int m_selq, m_rl, m_rs;
    int m_ml [N];
    int m_ms [N];
    bit [N-1:0] m_prec, m_fast;
    bit m_done, m_sd;

    always @(posedge clk) begin
        int sel, clr, tl, ts;
        bit r, le, se;
        sel = int'(ref_sel);
        clr = (set_thr > hyst) ? int'(set_thr) - int'(hyst) : 0;
        if (rst || sel != m_selq) begin
            if (rst) begin m_selq = 0; m_prec = '0; m_fast = '0; end
            else m_selq = sel;
            m_rl = 0; m_rs = 0; m_done = 0; m_sd = 0;
            for (int i = 0; i < N; i++) begin m_ml[i] = 0; m_ms[i] = 0; end
        end else begin
            r  = (sel < N) ? mon_edge[sel] : xtal_edge;   // R2
            le = r && (m_rl == L - 1);
            se = r && (m_rs == S - 1);
            for (int i = 0; i < N; i++) begin
                tl = m_ml[i] + int'(mon_edge[i]);
                ts = m_ms[i] + int'(mon_edge[i]);
                if (le) begin
                    if (tl == 0 || over(labs(tl - L), L, set_thr)) m_prec[i] = 1;
                    else if (!over(labs(tl - L), L, clr)) m_prec[i] = 0;
                    m_ml[i] = 0;
                end else m_ml[i] = tl;
                if (se) begin
                    m_fast[i] = over(labs(ts - S), S, 64000);
                    m_ms[i] = 0;
                end else m_ms[i] = ts;
            end
            m_rl = le ? 0 : m_rl + int'(r);
            m_rs = se ? 0 : m_rs + int'(r);
            m_done = le; m_sd = se;
        end
    end

    string cur_req = "R1";

    always @(negedge clk) begin
        if (!rst && (win_done || m_done || m_sd)) begin
            checks++;
            if (oof !== (m_prec | m_fast) || win_done !== m_done) begin
                errors++;
                $display("FAIL %s: oof=%b done=%b expected oof=%b done=%b",
                         cur_req, oof, win_done, m_prec | m_fast, m_done);
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            report();
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input bit ok, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    initial begin
        int wait_n;
        void'($urandom(32'd4711));
        run(4);
        chk("R1", oof == '0 && win_done == 1'b0, int'({oof, win_done}), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R1", oof == '0 && win_done == 1'b0, int'({oof, win_done}), 0);

        // R4 R6 R7 R10: crystal reference, exact, inside, far out, stopped
        cur_req = "R4 R6 R7 R10";
        inc[0] = ppm_inc(0.0);
        inc[1] = ppm_inc(200.0);
        inc[2] = ppm_inc(-1500.0);
        inc[3] = '0;
        run(2 * L * 2 + 20);
        chk("R6", oof[3] == 1'b1, int'(oof[3]), 1);
        chk("R4", oof[2] == 1'b1 && oof[0] == 1'b0, int'(oof), 4'b1100);

        // R7: large jump caught by the coarse detector within a short window
        cur_req = "R7";
        inc[0] = ppm_inc(12000.0);
        run(2 * S * 2 + 10);
        chk("R7", oof[0] == 1'b1, int'(oof[0]), 1);
        inc[0] = ppm_inc(0.0);

        // R5: hysteresis hold then clear
        cur_req = "R5";
        set_thr = 13'd8000; hyst = 13'd4000;
        inc[1] = ppm_inc(1500.0);
        run(2 * L * 2 + 20);
        chk("R5", oof[1] == 1'b1, int'(oof[1]), 1);
        inc[1] = inc[4]; acc[1] = acc[4];
        run(2 * L * 2 + 20);
        chk("R5", oof[1] == 1'b0, int'(oof[1]), 0);

        // R9 R2: switch to input 0 mid-window, time the next strobe
        cur_req = "R9 R2";
        run(300);
        ref_sel = 3'd0;
        wait_n = 0;
        @(negedge clk);
        while (!win_done && wait_n < 3 * L) begin @(negedge clk); wait_n++; end
        chk("R9", wait_n >= 2 * L - 3, wait_n, 2 * L - 2);
        run(2);
        chk("R2", oof[0] == 1'b0, int'(oof[0]), 0);

        // R2: upper crystal code
        ref_sel = 3'd7;
        run(2 * L * 2 + 20);

        // random epochs
        cur_req = "R3 R4 R5 R7 R8";
        for (int ep = 0; ep < 14; ep++) begin
            int pick, sel;
            for (int i = 0; i < N; i++) begin
                pick = int'($urandom_range(0, 4));
                case (pick)
                    0: inc[i] = inc[4];
                    1: inc[i] = ppm_inc(real'($urandom_range(0, 600)) - 300.0);
                    2: inc[i] = ppm_inc(($urandom_range(0, 1) ? 1.0 : -1.0) * real'($urandom_range(400, 2000)));
                    3: inc[i] = ppm_inc(($urandom_range(0, 1) ? 1.0 : -1.0) * real'($urandom_range(6000, 20000)));
                    default: inc[i] = '0;
                endcase
            end
            sel = int'($urandom_range(0, 5));
            if (sel < N && inc[sel] == '0) sel = 4;
            ref_sel = 3'(sel);
            set_thr = 13'($urandom_range(500, 8000));
            hyst    = 13'($urandom_range(0, 8000));
            run(2 * L * 2 + 30);
        end
        report();
    end
endmodule